// File: doc/BRIEF.md
# Previous-Result Serial Reader

This block is a secondary serial read-out port for a successive-approximation converter. When the latch strobe falls, it arms a capture. On the next rising edge of an independent read clock, it copies the converter's finished result into its own shift register. It then shifts the word out MSB first on the falling edges of the read clock. After the last bit it keeps driving the LSB until the next capture.

The same strobe also stands in for the external convert command. The block raises a convert pulse toward the sequencer and drops it on the first falling read-clock edge after the strobe. That falling edge starts the next conversion, while this port is still sending the previous one.

The read clock has to run well above the conversion clock so that the capture happens before the sequencer clears its result register. For this reason the block flags a sequencing error if the conversion clock rises while a capture is still pending. It also flags an error if the strobe is released before the capture happens.

All three input clocks (read, conversion and strobe) are treated as level signals. They are sampled on a fast system clock, and their edges are detected against the value from the previous sample.

Top module: `prev_result_reader`

## Requirements
- R1: While reset is asserted, and right after it, `sdata_o`, `cnv_cmd_o` and `seq_err_o` are all 0.
- R2: A falling edge of `latch_n_i` arms a capture. The first rising edge of `rd_clk_i` seen in a later sample loads `result_i` into the shift register, and bit W-1 appears on `sdata_o` one system clock later.
- R3: After a load, each falling edge of `rd_clk_i` moves `sdata_o` on to the next lower bit, MSB first down to bit 0.
- R4: Once bit 0 is on `sdata_o`, later falling read-clock edges have no effect. The LSB is held until the next load.
- R5: `cnv_cmd_o` rises one system clock after a strobe falling edge is sampled. It falls one system clock after the first read-clock falling edge sampled after that one; a read-clock falling edge in the same sample as the strobe edge does not end it.
- R6: `seq_err_o` goes to 1 if a rising edge of `cnv_clk_i` is sampled while a capture is pending, including in the same sample as the load edge. It is cleared by the next strobe falling edge.
- R7: `seq_err_o` goes to 1 if `latch_n_i` rises while a capture is still pending.
- R8: A new strobe falling edge during a read-out arms a fresh capture, and the next rising read-clock edge reloads the word.
- R9: `result_i` has no effect on `sdata_o` except at the load edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_clk_i | input | 1 | Independent read-out clock |
| cnv_clk_i | input | 1 | Conversion clock of the sequencer |
| latch_n_i | input | 1 | Active-low latch strobe |
| result_i | input | W | Result register of the sequencer |
| sdata_o | output | 1 | Serial data of the previous result, MSB first |
| cnv_cmd_o | output | 1 | Generated convert command (its falling edge starts a conversion) |
| seq_err_o | output | 1 | Sequencing error flag |

## Verification
The bench lets the strobe fall at every phase of the read clock. A design that counted the read edge coinciding with the strobe as the load edge would show its word one read cycle early, and would end the convert pulse at once.

It changes `result_i` in the middle of a read-out. A design that shifted from the live input, instead of from a captured copy, would then emit a corrupted word.

It runs more than W falling read edges after each load. A design that kept shifting would push zeros out instead of holding the LSB.

Finally, it speeds up the conversion clock and releases the strobe early. A design with a missing or wrong error window would either stay silent on these two cases or raise the flag on legal ones.

// File: rtl/prev_result_reader.sv
module prev_result_reader #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rd_clk_i,
  input  logic         cnv_clk_i,
  input  logic         latch_n_i,
  input  logic [W-1:0] result_i,
  output logic         sdata_o,
  output logic         cnv_cmd_o,
  output logic         seq_err_o
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic rd_q, cv_q, lat_q, armed;
  logic [W-1:0] shreg;
  logic [CW-1:0] cnt;

  wire rd_rise  = rd_clk_i & ~rd_q;
  wire rd_fall  = ~rd_clk_i & rd_q;
  wire cv_rise  = cnv_clk_i & ~cv_q;
  wire lat_fall = ~latch_n_i & lat_q;
  wire lat_rise = latch_n_i & ~lat_q;
  wire load     = armed & rd_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= 1'b0;
      cv_q  <= 1'b0;
      lat_q <= 1'b1;
    end else begin
      rd_q  <= rd_clk_i;
      cv_q  <= cnv_clk_i;
      lat_q <= latch_n_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed <= 1'b0;
    else if (lat_fall) armed <= 1'b1;
    else if (load)     armed <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= LAST;
    end else if (load) begin
      shreg <= result_i;
      cnt   <= '0;
    end else if (rd_fall && cnt != LAST) begin
      shreg <= shreg << 1;
      cnt   <= cnt + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnv_cmd_o <= 1'b0;
    else if (lat_fall) cnv_cmd_o <= 1'b1;
    else if (rd_fall)  cnv_cmd_o <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              seq_err_o <= 1'b0;
    else if (lat_fall)                       seq_err_o <= 1'b0;
    else if (armed && (cv_rise || lat_rise)) seq_err_o <= 1'b1;
  end

  assign sdata_o = shreg[W-1];
endmodule

module prev_result_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic rd_clk_i,
  input logic cnv_clk_i,
  input logic latch_n_i,
  input logic sdata_o,
  input logic cnv_cmd_o,
  input logic seq_err_o
);
  // R5
  cmd_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cnv_cmd_o) |-> (!$past(latch_n_i) && $past(latch_n_i, 2)));
  // R5
  cmd_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cnv_cmd_o) |-> (!$past(rd_clk_i) && $past(rd_clk_i, 2)));
  // R3
  data_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata_o) |-> ($past(rd_clk_i) != $past(rd_clk_i, 2)));
  // R6
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_err_o) |-> (($past(cnv_clk_i) && !$past(cnv_clk_i, 2)) ||
                          ($past(latch_n_i) && !$past(latch_n_i, 2))));
  // R6
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seq_err_o) |-> (!$past(latch_n_i) && $past(latch_n_i, 2)));
endmodule

bind prev_result_reader prev_result_reader_chk u_chk (.*);

// File: tb/tb_prev_result_reader.sv
`timescale 1ns/1ps
module tb_prev_result_reader;
  localparam int W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_clk_i = 1'b0, cnv_clk_i = 1'b0, latch_n_i = 1'b1;
  logic [W-1:0] result_i = '0;
  logic sdata_o, cnv_cmd_o, seq_err_o;

  int tests = 0, fails = 0;
  int rd_half = 2, cv_half = 6, rd_cnt = 0, cv_cnt = 0;

  // reference model state
  bit m_q[$];
  bit m_armed = 0, m_cmd = 0, m_err = 0;
  bit p_rd = 0, p_cv = 0, p_lat = 1;

  prev_result_reader #(.W(W)) dut (.*);

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q = {}; m_armed = 0; m_cmd = 0; m_err = 0;
      p_rd = 0; p_cv = 0; p_lat = 1;
    end else begin
      bit rr, rf, cr, lf, lr, ld;
      rr = rd_clk_i && !p_rd;  rf = !rd_clk_i && p_rd;
      cr = cnv_clk_i && !p_cv;
      lf = !latch_n_i && p_lat; lr = latch_n_i && !p_lat;
      ld = m_armed && rr;
      if (lf) m_err = 0;
      else if (m_armed && (cr || lr)) m_err = 1;
      if (ld) begin
        m_q = {};
        for (int i = W - 1; i >= 0; i--) m_q.push_back(result_i[i]);
      end else if (rf && m_q.size() > 1) void'(m_q.pop_front());
      if (lf) m_cmd = 1; else if (rf) m_cmd = 0;
      if (lf) m_armed = 1; else if (ld) m_armed = 0;
      p_rd = rd_clk_i; p_cv = cnv_clk_i; p_lat = latch_n_i;
    end
  end

  task automatic chk(input logic act, input logic exp, input string req);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk(sdata_o, (m_q.size() > 0) ? m_q[0] : 1'b0, "R2/R3/R4/R8/R9 sdata");
    chk(cnv_cmd_o, m_cmd, "R5 cnv_cmd");
    chk(seq_err_o, m_err, "R6/R7 seq_err");
    if (++rd_cnt >= rd_half) begin rd_cnt = 0; rd_clk_i = ~rd_clk_i; end
    if (++cv_cnt >= cv_half) begin cv_cnt = 0; cnv_clk_i = ~cnv_clk_i; end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic strobe(input logic [W-1:0] val, input int low);
    result_i = val;
    latch_n_i = 1'b0;
    run(low);
    latch_n_i = 1'b1;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sdata_o, 1'b0, "R1 sdata");
    chk(cnv_cmd_o, 1'b0, "R1 cnv_cmd");
    chk(seq_err_o, 1'b0, "R1 seq_err");
    rst_n = 1'b1;
    run(5);
    // R2 R3 R4: full word, then hold LSB
    strobe(16'hA5C3, 10);
    run(6);
    result_i = 16'h0F0F;  // R9: input change mid-readout ignored
    run(80);
    // strobe at every read-clock phase
    for (int ph = 0; ph < 4; ph++) begin
      run(ph + 1);
      strobe(16'h8001 ^ 16'(ph * 16'h1111), 9);
      run(75);
    end
    // R8: restart during readout
    strobe(16'h7FFE, 9);
    run(20);
    strobe(16'h1234, 9);
    run(80);
    // R6: conversion clock too fast
    cv_half = 1;
    strobe(16'hBEEF, 9);
    run(70);
    cv_half = 6;
    run(12);
    strobe(16'h4321, 9);
    run(70);
    // R7: strobe released before the load edge
    run(1);
    strobe(16'hCAFE, 1);
    run(70);
    // recover with a legal strobe
    strobe(16'hFFFF, 9);
    run(70);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule